// File: doc/BRIEF.md
# Stretchable Half-Rate Clock and Reset Qualifier

This block sits at the root of a small processor core. It runs on a fast input clock and produces two half-rate clock waveforms as registered outputs. The processor clock can be held low while the external wait request is high. The timing clock keeps toggling at the same rate and phase whatever the wait request does. A one-cycle strobe marks every rising edge of the processor clock, which is where each processor cycle begins.

The block also filters the external reset. The internal reset is raised only after the reset input has been seen high on a minimum number of consecutive input-clock rising edges. It is released on the first rising edge that sees the input low. While the internal reset is active, both clocks and the strobe are driven low. The eight bus status lines coming from the core are replaced by their fixed reset levels.

Top module: `pclk_gen_top`

## Requirements
- R1: Outside internal reset, `tclk_o` changes value on every rising edge of `iclk`, so it runs at half the input rate.
- R2: `pclk_o` is high only while `tclk_o` is high. It rises only on an edge where `tclk_o` rises, and it falls together with `tclk_o`.
- R3: If `wait_in` is high on an edge where `tclk_o` rises, `pclk_o` stays low for that whole timing period of two `iclk` cycles. The check repeats at every following rising point, so the stretch lasts a whole number of periods while `tclk_o` keeps toggling.
- R4: `cyc_start_o` is high for exactly the one `iclk` cycle that follows each rising edge of `pclk_o`. It is never high while `pclk_o` is held low.
- R5: `core_rst_o` rises on the 4th consecutive rising edge of `iclk` at which `rst_in` is sampled high.
- R6: If `rst_in` is high on fewer than 4 consecutive edges, `core_rst_o` stays low and the clocks keep running. The edge count restarts from zero whenever `rst_in` is sampled low.
- R7: `core_rst_o` falls on the first edge at which `rst_in` is sampled low. `pclk_o` and `tclk_o` stay low through the following cycle and start together from their low phase.
- R8: While `core_rst_o` is high, `pclk_o`, `tclk_o` and `cyc_start_o` are low from the edge after it rose.
- R9: While `core_rst_o` is high, `bus_stat_o` equals 8'h7F; otherwise it equals `bus_stat_i`. The bits are, from bit 0 up: fetch, boot-space, memory read (low means write), upper byte select, lower byte select, peripheral bus select (active low), peripheral read (low means write), interrupt acknowledge. Bits 0 to 6 reset high and bit 7 resets low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| iclk | input | 1 | Fast input clock; all logic is clocked on its rising edge |
| rst_in | input | 1 | External reset request, active high, width-qualified |
| wait_in | input | 1 | Wait request; high holds the processor clock low |
| bus_stat_i | input | 8 | Bus status bits from the core |
| pclk_o | output | 1 | Stretchable half-rate processor clock |
| tclk_o | output | 1 | Free-running half-rate timing clock |
| cyc_start_o | output | 1 | One-cycle strobe at each processor clock rise |
| core_rst_o | output | 1 | Qualified internal reset, active high |
| bus_stat_o | output | 8 | Bus status bits, forced to reset levels during reset |

## Verification
The bound assertions check on every cycle that the timing clock toggles outside reset and that the processor clock never stands high without the timing clock. They also check that a wait request at a rising point keeps the processor clock low, that the strobe marks only processor clock rises, and that the clocks are quiet and released as specified around reset. The exact count of four edges before reset takes effect, the rejection of pulses one to three edges long, and long multi-period stretches can be shown only by the bench's scenarios. For those, the bench compares every output against its behavioural model on every clock.

// File: rtl/pclk_gen_pkg.sv
package pclk_gen_pkg;

    localparam int STAT_W = 8;
    // bits 0..6 idle high, bit 7 (interrupt acknowledge) idle low
    localparam logic [STAT_W-1:0] STAT_RST = 8'h7F;

    typedef struct packed {
        logic tclk;
        logic pclk;
        logic strobe;
    } clk_state_t;

endpackage

// File: rtl/pclk_rst_qual.sv
module pclk_rst_qual #(
    parameter int MIN_EDGES = 4
) (
    input  logic iclk,
    input  logic rst_in,
    output logic core_rst
);
    localparam int CNT_W = $clog2(MIN_EDGES + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_EDGES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_in) begin
            // this edge completes the run when cnt already holds MIN_EDGES-1
            if (st_q.cnt >= CNT_TOP) begin
                st_d.cnt    = CNT_TOP;
                st_d.active = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else begin
            st_d.cnt    = '0;
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge iclk) begin
        st_q <= st_d;
    end

    assign core_rst = st_q.active;

endmodule

// File: rtl/pclk_divider.sv
module pclk_divider
    import pclk_gen_pkg::*;
(
    input  logic iclk,
    input  logic hold_rst,
    input  logic wait_in,
    output logic pclk,
    output logic tclk,
    output logic strobe
);
    clk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_rst) begin
            st_d = '0;
        end else if (!st_q.tclk) begin
            // rising point: the processor clock follows only without wait
            st_d.tclk   = 1'b1;
            st_d.pclk   = !wait_in;
            st_d.strobe = !wait_in;
        end else begin
            st_d.tclk   = 1'b0;
            st_d.pclk   = 1'b0;
            st_d.strobe = 1'b0;
        end
    end

    always_ff @(posedge iclk) begin
        st_q <= st_d;
    end

    assign pclk   = st_q.pclk;
    assign tclk   = st_q.tclk;
    assign strobe = st_q.strobe;

endmodule

// File: rtl/pclk_stat_gate.sv
module pclk_stat_gate #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         hold_rst,
    input  logic [W-1:0] stat_i,
    output logic [W-1:0] stat_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            stat_o[b] = hold_rst ? RST_VAL[b] : stat_i[b];
        end
    end

endmodule

// File: rtl/pclk_gen_top.sv
module pclk_gen_top
    import pclk_gen_pkg::*;
#(
    parameter int MIN_EDGES = 4
) (
    input  logic              iclk,
    input  logic              rst_in,
    input  logic              wait_in,
    input  logic [STAT_W-1:0] bus_stat_i,
    output logic              pclk_o,
    output logic              tclk_o,
    output logic              cyc_start_o,
    output logic              core_rst_o,
    output logic [STAT_W-1:0] bus_stat_o
);
    logic core_rst;

    pclk_rst_qual #(.MIN_EDGES(MIN_EDGES)) u_qual (
        .iclk     (iclk),
        .rst_in   (rst_in),
        .core_rst (core_rst)
    );

    pclk_divider u_div (
        .iclk     (iclk),
        .hold_rst (core_rst),
        .wait_in  (wait_in),
        .pclk     (pclk_o),
        .tclk     (tclk_o),
        .strobe   (cyc_start_o)
    );

    pclk_stat_gate #(.W(STAT_W), .RST_VAL(STAT_RST)) u_stat (
        .hold_rst (core_rst),
        .stat_i   (bus_stat_i),
        .stat_o   (bus_stat_o)
    );

    assign core_rst_o = core_rst;

endmodule

// File: rtl/pclk_gen_chk.sv
module pclk_gen_chk (
    input logic       iclk,
    input logic       rst_in,
    input logic       wait_in,
    input logic       pclk_o,
    input logic       tclk_o,
    input logic       cyc_start_o,
    input logic       core_rst_o,
    input logic [7:0] bus_stat_o
);
    // properties are armed once the first qualified reset has been seen
    logic armed_q = 1'b0;
    always_ff @(posedge iclk) begin
        armed_q <= armed_q | core_rst_o;
    end

    a_r1_tclk_toggles: assert property (@(posedge iclk) disable iff (!armed_q)
        !core_rst_o |=> (tclk_o != $past(tclk_o)));

    a_r2_pclk_inside_tclk: assert property (@(posedge iclk) disable iff (!armed_q)
        pclk_o |-> tclk_o);

    a_r3_wait_holds_low: assert property (@(posedge iclk) disable iff (!armed_q)
        (!core_rst_o && !tclk_o && wait_in) |=> !pclk_o);

    a_r4_strobe_on_rise: assert property (@(posedge iclk) disable iff (!armed_q)
        cyc_start_o |-> (pclk_o && !$past(pclk_o)));

    a_r4_rise_has_strobe: assert property (@(posedge iclk) disable iff (!armed_q)
        $rose(pclk_o) |-> cyc_start_o);

    a_r6_no_rst_without_req: assert property (@(posedge iclk) disable iff (!armed_q)
        (!core_rst_o && !rst_in) |=> !core_rst_o);

    a_r7_release: assert property (@(posedge iclk) disable iff (!armed_q)
        (core_rst_o && !rst_in) |=> (!core_rst_o && !pclk_o && !tclk_o));

    a_r8_quiet_in_reset: assert property (@(posedge iclk) disable iff (!armed_q)
        core_rst_o |=> (!pclk_o && !tclk_o && !cyc_start_o));

    a_r9_stat_levels: assert property (@(posedge iclk) disable iff (!armed_q)
        core_rst_o |-> (bus_stat_o == 8'h7F));

endmodule

bind pclk_gen_top pclk_gen_chk u_chk (
    .iclk        (iclk),
    .rst_in      (rst_in),
    .wait_in     (wait_in),
    .pclk_o      (pclk_o),
    .tclk_o      (tclk_o),
    .cyc_start_o (cyc_start_o),
    .core_rst_o  (core_rst_o),
    .bus_stat_o  (bus_stat_o)
);

// File: tb/pclk_gen_top_tb_top.sv
`timescale 1ns/1ps
module pclk_gen_top_tb_top;

    logic       iclk = 1'b0;
    logic       rst_in = 1'b0;
    logic       wait_in = 1'b0;
    logic [7:0] bus_stat_i = 8'h00;
    logic       pclk_o, tclk_o, cyc_start_o, core_rst_o;
    logic [7:0] bus_stat_o;

    always #2.5 iclk = ~iclk;   // 200 MHz

    pclk_gen_top dut_i (
        .iclk        (iclk),
        .rst_in      (rst_in),
        .wait_in     (wait_in),
        .bus_stat_i  (bus_stat_i),
        .pclk_o      (pclk_o),
        .tclk_o      (tclk_o),
        .cyc_start_o (cyc_start_o),
        .core_rst_o  (core_rst_o),
        .bus_stat_o  (bus_stat_o)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int rcnt     = 0;
    bit m_rst    = 0;
    bit m_rst_pv = 0;
    bit m_t = 0, m_p = 0, m_s = 0;
    bit valid    = 0;
    string short_tag = "R5";

    always @(posedge iclk) begin
        bit old_rst;
        old_rst  = m_rst;
        m_rst_pv = m_rst;
        if (rst_in) begin
            rcnt++;
            if (rcnt >= 4) m_rst = 1;
        end else begin
            rcnt  = 0;
            m_rst = 0;
        end
        if (old_rst) begin
            m_t = 0; m_p = 0; m_s = 0;
        end else if (!m_t) begin
            m_t = 1; m_p = !wait_in; m_s = !wait_in;
        end else begin
            m_t = 0; m_p = 0; m_s = 0;
        end
        if (m_rst) valid = 1;
    end

    // compare every cycle, away from the edge
    always @(posedge iclk) begin
        #1;
        if (valid) begin
            chk(core_rst_o == m_rst, short_tag, core_rst_o, m_rst);
            if (m_rst || m_rst_pv) begin
                chk(tclk_o == m_t, m_rst ? "R8 tclk" : "R7 tclk", tclk_o, m_t);
                chk(pclk_o == m_p, m_rst ? "R8 pclk" : "R7 pclk", pclk_o, m_p);
                chk(cyc_start_o == m_s, "R8 strobe", cyc_start_o, m_s);
            end else begin
                chk(tclk_o == m_t, "R1 tclk", tclk_o, m_t);
                chk(pclk_o == m_p, wait_in ? "R3 pclk" : "R2 pclk", pclk_o, m_p);
                chk(cyc_start_o == m_s, "R4 strobe", cyc_start_o, m_s);
            end
            chk(bus_stat_o == (m_rst ? 8'h7F : bus_stat_i), "R9 status",
                bus_stat_o, m_rst ? 8'h7F : bus_stat_i);
        end
    end

    task automatic run(input int n, input bit rnd_wait);
        for (int i = 0; i < n; i++) begin
            @(negedge iclk);
            bus_stat_i = 8'($urandom);
            if (rnd_wait) wait_in = ($urandom % 3) == 0;
        end
    endtask

    task automatic pulse_rst(input int n);
        @(negedge iclk);
        rst_in = 1;
        repeat (n - 1) @(negedge iclk);
        @(negedge iclk);
        rst_in = 0;
    endtask

    initial begin
        // initial qualified reset
        @(negedge iclk);
        rst_in = 1;
        repeat (6) @(negedge iclk);
        chk(core_rst_o == 1, "R5 reset state", core_rst_o, 1);
        chk(pclk_o == 0 && tclk_o == 0, "R8 reset clocks", {pclk_o, tclk_o}, 0);
        chk(bus_stat_o == 8'h7F, "R9 reset levels", bus_stat_o, 8'h7F);
        rst_in = 0;
        run(20, 0);                         // R1 R2 R4 free running
        // R3: long stretch
        @(negedge iclk); wait_in = 1;
        run(9, 0);
        @(negedge iclk); wait_in = 0;
        run(10, 0);
        run(60, 1);                         // R3 R4 random wait
        wait_in = 0;
        // R6: short pulses ignored
        short_tag = "R6";
        for (int w = 1; w <= 3; w++) begin
            pulse_rst(w);
            run(6, 1);
        end
        // R6 count restarts: 3 high, 1 low, 3 high
        pulse_rst(3);
        pulse_rst(3);
        run(6, 0);
        // R5: exactly 4 edges qualifies, then R7 release
        short_tag = "R5";
        pulse_rst(4);
        run(8, 1);
        wait_in = 0;
        pulse_rst(10);
        @(negedge iclk);
        chk(core_rst_o == 0 && tclk_o == 0, "R7 release low phase", {core_rst_o, tclk_o}, 0);
        run(20, 1);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule